// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch

A non-blocking single-bit crosspoint that routes any of `N_IN` data inputs to each of `N_OUT` main outputs plus one extra monitor output. Every output owns an independent selector, so one input may feed any number of outputs at the same time. Routing is set up in two stages. First, a staging (program) entry is written for one output at a time. Then a single commit strobe copies all staging entries into the live selection registers. Building a new map therefore never disturbs traffic that is already flowing.

All strobes are sampled on one clock. A staging write happens on the clock where the load strobe is first seen low after having been high. The monitor output has its own staging strobe and takes only the input address.

Reset parks every output on input 0. The first commit after reset, if no other strobe comes before it, sets up a straight pass-through map instead. The most significant input-address bit picks the lower or the upper half of the inputs.

Top module: `xp_switch`

## Requirements
- R1: Main output k and the monitor output (dout_o bit N_OUT) each equal din_i at the index held in that output's live selection register, combinationally when REG_OUT=0. Several outputs may select the same input.
- R2: Staging writes from load_i or mon_load_i leave dout_o unchanged until a commit is sampled.
- R3: oaddr_i is the binary index of a main output (0 = output 0) and iaddr_i is the binary index of an input (0 = input 0).
- R4: A staging write for main output oaddr_i happens on the first clock edge where load_i is sampled low after being high. It stores the iaddr_i and oaddr_i values present at that edge.
- R5: A clock edge with commit_i high copies every staging entry into the live registers. Outputs whose staging entry was not rewritten keep their selection.
- R6: mon_load_i stages iaddr_i for the monitor output on its falling sample, ignoring oaddr_i and load_i. The monitor output changes only after a commit.
- R7: If the load falling sample and a commit fall on the same edge, the new selection is live right after that edge.
- R8: While rst is high, every staging and live entry is 0, so all N_OUT+1 outputs carry din_i[0].
- R9: A commit that is the first strobe after reset is released loads pass-through into both stages. With iaddr_i MSB = 0, output i is routed to input i. With iaddr_i MSB = 1, output i is routed to input N_OUT+i.
- R10: A pass-through commit routes the monitor output to input 0.
- R11: Once any load, monitor load or commit has been sampled after reset, later commits are plain copies, regardless of iaddr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all strobes and registers |
| rst | input | 1 | Active-high asynchronous reset to input 0 everywhere |
| load_i | input | 1 | Staging strobe for a main output |
| mon_load_i | input | 1 | Staging strobe for the monitor output |
| commit_i | input | 1 | Copies all staging entries into the live registers |
| oaddr_i | input | $clog2(N_OUT) | Main output index for staging |
| iaddr_i | input | $clog2(N_IN) | Input index; MSB picks the pass-through half |
| din_i | input | N_IN | Data inputs |
| dout_o | output | N_OUT+1 | Main outputs, monitor at the top bit |

## Verification
The bench uses the default build: 64 inputs, 32 main outputs and combinational outputs (REG_OUT=0). At that size the pass-through upper half reaches input 63, and the 5-bit output address covers every main output. Each live selection is read back in full: the bench drives din_i with each address bit spread across the inputs, plus its inverse. This reveals every output's exact input index, including input 0, input 63 and shared inputs.

// File: rtl/xp_pkg.sv
package xp_pkg;
   localparam int unsigned XP_N_IN_DEF  = 64;
   localparam int unsigned XP_N_OUT_DEF = 32;
   localparam int unsigned XP_STB_N     = 3;

   typedef enum int unsigned {
      STB_LOAD = 0,
      STB_MON  = 1,
      STB_CMT  = 2
   } xp_stb_e;
endpackage

// File: rtl/xp_strobe_edge.sv
module xp_strobe_edge #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] stb_i,
   output logic [N-1:0] fall_o
);
   if (N < 1) begin : g_bad_n
      $error("xp_strobe_edge: N must be at least 1");
   end

   for (genvar s = 0; s < N; s++) begin : g_stb
      logic q;
      always_ff @(posedge clk or posedge rst) begin
         if (rst) q <= 1'b0;
         else     q <= stb_i[s];
      end
      assign fall_o[s] = q & ~stb_i[s];

      // a falling sample needs a high sample first, so never twice in a row (R4)
      assert_fall_single_R4: assert property (@(posedge clk) disable iff (rst)
         fall_o[s] |=> !fall_o[s]);
   end
endmodule

// File: rtl/xp_cfg_bank.sv
module xp_cfg_bank #(
   parameter int unsigned N_IN  = 64,
   parameter int unsigned N_OUT = 32,
   localparam int unsigned SEL_W = $clog2(N_IN),
   localparam int unsigned OA_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1,
   localparam int unsigned N_ALL = N_OUT + 1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   load_lvl,
   input  logic                   mon_lvl,
   input  logic                   commit,
   input  logic                   load_fall,
   input  logic                   mon_fall,
   input  logic [OA_W-1:0]        oaddr,
   input  logic [SEL_W-1:0]       iaddr,
   output logic [N_ALL*SEL_W-1:0] cfg_o
);
   logic [SEL_W-1:0] prog_q   [N_ALL];
   logic [SEL_W-1:0] cfg_q    [N_ALL];
   logic [SEL_W-1:0] prog_nxt [N_ALL];
   logic [SEL_W-1:0] pt_val   [N_ALL];
   logic             fresh_q;
   logic             pt_go;

   assign pt_go = commit & fresh_q & ~load_lvl & ~mon_lvl;

   for (genvar k = 0; k < N_ALL; k++) begin : g_ent
      if (k < N_OUT) begin : g_main
         assign prog_nxt[k] = (load_fall && (oaddr == OA_W'(k))) ? iaddr : prog_q[k];
         assign pt_val[k]   = iaddr[SEL_W-1] ? SEL_W'(N_OUT + k) : SEL_W'(k);
      end else begin : g_mon
         assign prog_nxt[k] = mon_fall ? iaddr : prog_q[k];
         assign pt_val[k]   = '0;
      end
      assign cfg_o[k*SEL_W +: SEL_W] = cfg_q[k];
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         fresh_q <= 1'b1;
         for (int k = 0; k < N_ALL; k++) begin
            prog_q[k] <= '0;
            cfg_q[k]  <= '0;
         end
      end else begin
         if (load_lvl | mon_lvl | commit) fresh_q <= 1'b0;
         for (int k = 0; k < N_ALL; k++) begin
            if (pt_go) begin
               prog_q[k] <= pt_val[k];
               cfg_q[k]  <= pt_val[k];
            end else begin
               prog_q[k] <= prog_nxt[k];
               if (commit) cfg_q[k] <= prog_nxt[k];
            end
         end
      end
   end

   assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !commit |=> $stable(cfg_o));

   assert_reset_zero_R8: assert property (@(posedge clk)
      (rst && $past(rst)) |-> (cfg_o == '0));

   assert_fresh_once_R11: assert property (@(posedge clk) disable iff (rst)
      !fresh_q |=> !fresh_q);

   assert_mon_pt_R10: assert property (@(posedge clk) disable iff (rst)
      pt_go |=> (cfg_o[N_OUT*SEL_W +: SEL_W] == '0));
endmodule

// File: rtl/xp_sel_row.sv
module xp_sel_row #(
   parameter int unsigned N_IN    = 64,
   parameter bit          REG_OUT = 1'b0,
   localparam int unsigned SEL_W  = $clog2(N_IN)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_IN-1:0]  din,
   input  logic [SEL_W-1:0] sel,
   output logic             q
);
   logic pick;
   assign pick = din[sel];

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or posedge rst) begin
         if (rst) q <= 1'b0;
         else     q <= pick;
      end
   end else begin : g_comb
      assign q = pick;
   end
endmodule

// File: rtl/xp_switch.sv
module xp_switch
   import xp_pkg::*;
#(
   parameter int unsigned N_IN    = XP_N_IN_DEF,
   parameter int unsigned N_OUT   = XP_N_OUT_DEF,
   parameter bit          REG_OUT = 1'b0,
   localparam int unsigned SEL_W  = $clog2(N_IN),
   localparam int unsigned OA_W   = (N_OUT > 1) ? $clog2(N_OUT) : 1,
   localparam int unsigned N_ALL  = N_OUT + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic             mon_load_i,
   input  logic             commit_i,
   input  logic [OA_W-1:0]  oaddr_i,
   input  logic [SEL_W-1:0] iaddr_i,
   input  logic [N_IN-1:0]  din_i,
   output logic [N_ALL-1:0] dout_o
);
   if ((N_IN & (N_IN - 1)) != 0 || N_IN < 2) begin : g_bad_in
      $error("xp_switch: N_IN must be a power of two");
   end
   if (N_OUT < 1 || 2 * N_OUT > N_IN) begin : g_bad_out
      $error("xp_switch: N_OUT must lie in 1..N_IN/2");
   end

   logic [XP_STB_N-1:0]    stb;
   logic [XP_STB_N-1:0]    fall;
   logic [N_ALL*SEL_W-1:0] cfg;

   assign stb[STB_LOAD] = load_i;
   assign stb[STB_MON]  = mon_load_i;
   assign stb[STB_CMT]  = commit_i;

   xp_strobe_edge #(.N(XP_STB_N)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .stb_i  (stb),
      .fall_o (fall)
   );

   xp_cfg_bank #(.N_IN(N_IN), .N_OUT(N_OUT)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .load_lvl  (load_i),
      .mon_lvl   (mon_load_i),
      .commit    (commit_i),
      .load_fall (fall[STB_LOAD]),
      .mon_fall  (fall[STB_MON]),
      .oaddr     (oaddr_i),
      .iaddr     (iaddr_i),
      .cfg_o     (cfg)
   );

   for (genvar k = 0; k < N_ALL; k++) begin : g_row
      xp_sel_row #(.N_IN(N_IN), .REG_OUT(REG_OUT)) u_row (
         .clk (clk),
         .rst (rst),
         .din (din_i),
         .sel (cfg[k*SEL_W +: SEL_W]),
         .q   (dout_o[k])
      );
   end
endmodule

// File: tb/tb_xp_switch.sv
module tb_xp_switch;
   localparam int CLK_PERIOD = 10;
   localparam int N_IN  = 64;
   localparam int N_OUT = 32;
   localparam int SEL_W = 6;
   localparam int OA_W  = 5;
   localparam int N_ALL = N_OUT + 1;
   localparam int N_VEC = 8;
   // {output index, input index}
   localparam logic [OA_W+SEL_W-1:0] VEC [N_VEC] = '{
      {5'd0, 6'd62}, {5'd31, 6'd63}, {5'd4, 6'd5}, {5'd5, 6'd5},
      {5'd6, 6'd5},  {5'd17, 6'd0},  {5'd20, 6'd33}, {5'd4, 6'd9}
   };

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             load_i = 1'b0, mon_load_i = 1'b0, commit_i = 1'b0;
   logic [OA_W-1:0]  oaddr_i = '0;
   logic [SEL_W-1:0] iaddr_i = '0;
   logic [N_IN-1:0]  din_i = '0;
   logic [N_ALL-1:0] dout_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int prog_m [N_ALL];
   int cfg_m  [N_ALL];

   xp_switch dut (
      .clk(clk), .rst(rst), .load_i(load_i), .mon_load_i(mon_load_i),
      .commit_i(commit_i), .oaddr_i(oaddr_i), .iaddr_i(iaddr_i),
      .din_i(din_i), .dout_o(dout_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input logic got, input logic exp, input string req, input int k);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s output %0d actual %b expected %b", req, k, got, exp);
      end
   endtask

   // decode every live selection through the outputs: one bit plane at a time
   task automatic verify_all(input string req);
      for (int b = 0; b < SEL_W; b++) begin
         for (int inv = 0; inv < 2; inv++) begin
            for (int j = 0; j < N_IN; j++) din_i[j] = j[b] ^ inv[0];
            #1;
            for (int k = 0; k < N_ALL; k++)
               chk(dout_o[k], cfg_m[k][b] ^ inv[0], req, k);
         end
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; load_i = 0; mon_load_i = 0; commit_i = 0;
      repeat (2) @(negedge clk);
      for (int k = 0; k < N_ALL; k++) begin prog_m[k] = 0; cfg_m[k] = 0; end
      verify_all("R8");
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic do_load(input int oa, input int ia);
      @(negedge clk);
      load_i = 1; oaddr_i = OA_W'(oa); iaddr_i = SEL_W'(ia);
      @(negedge clk);
      load_i = 0;
      @(negedge clk);
      prog_m[oa] = ia;
   endtask

   task automatic do_commit(input int ia);
      @(negedge clk);
      commit_i = 1; iaddr_i = SEL_W'(ia);
      @(negedge clk);
      commit_i = 0;
      for (int k = 0; k < N_ALL; k++) cfg_m[k] = prog_m[k];
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R8: reset state, all outputs on input 0
      do_reset();

      // R9 upper half and R10 monitor on input 0
      @(negedge clk); commit_i = 1; iaddr_i = 6'd32;
      @(negedge clk); commit_i = 0;
      for (int k = 0; k < N_OUT; k++) begin prog_m[k] = N_OUT + k; cfg_m[k] = N_OUT + k; end
      prog_m[N_OUT] = 0; cfg_m[N_OUT] = 0;
      verify_all("R9_R10");

      // R9 lower half
      do_reset();
      @(negedge clk); commit_i = 1; iaddr_i = 6'd0;
      @(negedge clk); commit_i = 0;
      for (int k = 0; k < N_OUT; k++) begin prog_m[k] = k; cfg_m[k] = k; end
      verify_all("R9");

      // R11: second commit is a plain copy even with MSB set
      do_commit(32);
      verify_all("R11");

      // R1 R3 R5: table of staging writes, multicast and extremes
      for (int v = 0; v < N_VEC; v++)
         do_load(int'(VEC[v][OA_W+SEL_W-1:SEL_W]), int'(VEC[v][SEL_W-1:0]));
      begin
         int save [N_ALL];
         save = cfg_m;
         verify_all("R2");
         do_commit(0);
         verify_all("R1_R3_R5");
         save[0] = save[0];
      end

      // R6: monitor load ignores oaddr_i, waits for commit
      @(negedge clk); mon_load_i = 1; oaddr_i = 5'd3; iaddr_i = 6'd17;
      @(negedge clk); mon_load_i = 0;
      @(negedge clk);
      prog_m[N_OUT] = 17;
      verify_all("R6");
      do_commit(0);
      verify_all("R6");

      // R4: address taken at the edge where load is first seen low
      @(negedge clk); load_i = 1; oaddr_i = 5'd12; iaddr_i = 6'd10;
      @(negedge clk); iaddr_i = 6'd11;
      @(negedge clk); load_i = 0; iaddr_i = 6'd40;
      @(negedge clk); iaddr_i = 6'd1;
      prog_m[12] = 40;
      do_commit(0);
      verify_all("R4");

      // R7: load falling sample and commit on the same edge
      @(negedge clk); load_i = 1; oaddr_i = 5'd9; iaddr_i = 6'd44;
      @(negedge clk); load_i = 0; commit_i = 1;
      @(negedge clk); commit_i = 0;
      prog_m[9] = 44;
      for (int k = 0; k < N_ALL; k++) cfg_m[k] = prog_m[k];
      verify_all("R7");

      // R11: a load before the first commit cancels pass-through
      do_reset();
      do_load(2, 7);
      do_commit(32);
      verify_all("R11");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule